// File: doc/BRIEF.md
# Cross-Domain Result Forwarding Scoreboard

This block records, for each result tag in flight, when the result becomes usable and by which consumer. Results move over three separate bypass networks, one per execution domain: scalar integer (64 bits wide, shared with the load and store units), SIMD integer (128 bits) and floating point (128 bits). A consumer in the same domain as the producer can take a value in its completion cycle. A consumer in a different domain waits one more cycle. A 256-bit result travels as two 128-bit halves at the same time. The low half goes on the floating-point network and the high half on the SIMD network. Each half pays the crossing cycle on its own, and the whole value is usable only when both halves are.

A producer writes one entry per cycle: a tag, a domain, a wide flag and a completion cycle. The write replaces anything held for that tag and takes effect on the next clock edge. The consumer lookup port is combinational. It takes a source tag, the consumer's domain and the current cycle count. It returns a ready flag for the present cycle, the earliest usable cycle, and the network that carries each half.

Top module: `fwd_scoreboard`

## Requirements
- R1: After reset, and for any tag never written since, a lookup returns ready low, earliest cycle all ones, and both network codes 3.
- R2: A legal write is visible to lookups from the cycle after the clock edge that takes it. A later write to the same tag replaces the earlier entry completely.
- R3: Domain codes are 0 for scalar integer, 1 for SIMD integer and 2 for floating point. For a narrow result whose producer domain equals the consumer domain, the earliest cycle equals the completion cycle.
- R4: For a narrow result whose producer domain differs from the consumer domain, the earliest cycle is the completion cycle plus one.
- R5: For a wide result the low-half network code is 2 and the high-half network code is 1, whatever domain was written. Each half adds one cycle when its network differs from the consumer domain, and the earliest cycle is the later of the two halves.
- R6: Ready is high exactly when the tag holds an entry, the consumer domain is legal, and the current cycle is greater than or equal to the earliest cycle.
- R7: A write with domain code 3 raises the write-error output in that cycle and leaves the stored entry unchanged.
- R8: A lookup with consumer domain code 3 raises the lookup-error output, holds ready low and reports the earliest cycle as all ones.
- R9: The earliest cycle saturates at all ones instead of wrapping when the crossing cycle is added.
- R10: For a narrow result the low-half network code is the producer domain and the high-half code is 3, meaning no high half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; clears every entry |
| cur_cyc | input | 16 | Current cycle count used to evaluate ready |
| wr_en | input | 1 | Producer write strobe |
| wr_tag | input | 5 | Destination tag written |
| wr_dom | input | 2 | Producer domain code |
| wr_wide | input | 1 | Result is 256 bits wide |
| wr_done | input | 16 | Completion cycle of the result |
| wr_err | output | 1 | Write carried an illegal domain and was dropped |
| rd_tag | input | 5 | Source tag looked up |
| rd_dom | input | 2 | Consumer domain code |
| rd_ready | output | 1 | Value usable in the current cycle |
| rd_earliest | output | 16 | Earliest cycle the value is usable |
| rd_lo_net | output | 2 | Network carrying the low half (3 = none) |
| rd_hi_net | output | 2 | Network carrying the high half (3 = none) |
| rd_err | output | 1 | Lookup carried an illegal consumer domain |

## Verification
The assertions assume that the cycle count does not wrap while entries are live, so completion and earliest values compare as plain unsigned numbers. They also assume that lookup tags stay below the tag count. The stimulus starts the cycle count at zero and raises it by one per clock, far below the 16-bit limit. The only exception is one write that deliberately places a completion cycle at all ones to show saturation. Tags are always drawn from the 32 legal values, and illegal domain codes are injected on both ports so that the error paths are exercised.

// File: rtl/fwd_sb_pkg.sv
package fwd_sb_pkg;

    localparam int CYC_W = 16;

    typedef enum logic [1:0] {
        DOM_INT = 2'd0,
        DOM_VEC = 2'd1,
        DOM_FP  = 2'd2,
        DOM_BAD = 2'd3
    } dom_e;

    localparam logic [1:0] NET_NONE = 2'd3;

    typedef struct packed {
        logic             valid;
        dom_e             dom;
        logic             wide;
        logic [CYC_W-1:0] done;
    } sb_entry_t;

    // add with clamp to all ones
    function automatic logic [CYC_W-1:0] sat_add(input logic [CYC_W-1:0] base,
                                                 input logic [CYC_W-1:0] inc);
        logic [CYC_W:0] sum;
        sum = {1'b0, base} + {1'b0, inc};
        return sum[CYC_W] ? {CYC_W{1'b1}} : sum[CYC_W-1:0];
    endfunction

    // network that carries a given half of a result
    function automatic logic [1:0] half_net(input logic wide, input dom_e dom, input int half);
        if (wide)
            return (half == 0) ? 2'(DOM_FP) : 2'(DOM_VEC);
        return (half == 0) ? 2'(dom) : NET_NONE;
    endfunction

endpackage

// File: rtl/fwd_sb_table.sv
module fwd_sb_table
    import fwd_sb_pkg::*;
#(
    parameter int NUM_TAGS = 32,
    localparam int TAG_W = $clog2(NUM_TAGS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [TAG_W-1:0] wr_tag,
    input  sb_entry_t        wr_ent,
    input  logic [TAG_W-1:0] rd_tag,
    output sb_entry_t        rd_ent
);

    sb_entry_t ents [NUM_TAGS];

    for (genvar g = 0; g < NUM_TAGS; g++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst)
                ents[g] <= '0;
            else if (wr_en && wr_tag == TAG_W'(g))
                ents[g] <= wr_ent;
        end
    end

    assign rd_ent = ents[rd_tag];

endmodule

// File: rtl/fwd_sb_eval.sv
module fwd_sb_eval
    import fwd_sb_pkg::*;
#(
    parameter int XING_PEN = 1
) (
    input  sb_entry_t        ent,
    input  logic [1:0]       cons_dom,
    input  logic [CYC_W-1:0] cur_cyc,
    output logic             ready,
    output logic [CYC_W-1:0] earliest,
    output logic [1:0]       lo_net,
    output logic [1:0]       hi_net,
    output logic             cons_err
);

    localparam int NHALF = 2;
    localparam logic [CYC_W-1:0] PEN = CYC_W'(XING_PEN);

    logic [1:0]       net    [NHALF];
    logic             active [NHALF];
    logic [CYC_W-1:0] arrive [NHALF];

    for (genvar h = 0; h < NHALF; h++) begin : g_half
        always_comb begin
            net[h]    = half_net(ent.wide, ent.dom, h);
            active[h] = (net[h] != NET_NONE);
            arrive[h] = sat_add(ent.done, (net[h] != cons_dom) ? PEN : '0);
        end
    end

    always_comb begin
        cons_err = (cons_dom == 2'(DOM_BAD));
        if (!ent.valid || cons_err) begin
            earliest = '1;
        end else begin
            earliest = arrive[0];
            for (int h = 1; h < NHALF; h++)
                if (active[h] && arrive[h] > earliest)
                    earliest = arrive[h];
        end
        ready  = ent.valid && !cons_err && (cur_cyc >= earliest);
        lo_net = ent.valid ? net[0] : NET_NONE;
        hi_net = ent.valid ? net[1] : NET_NONE;
    end

endmodule

// File: rtl/fwd_scoreboard.sv
module fwd_scoreboard
    import fwd_sb_pkg::*;
#(
    parameter int NUM_TAGS = 32,
    parameter int XING_PEN = 1,
    localparam int TAG_W = $clog2(NUM_TAGS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CYC_W-1:0] cur_cyc,
    input  logic             wr_en,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [1:0]       wr_dom,
    input  logic             wr_wide,
    input  logic [CYC_W-1:0] wr_done,
    output logic             wr_err,
    input  logic [TAG_W-1:0] rd_tag,
    input  logic [1:0]       rd_dom,
    output logic             rd_ready,
    output logic [CYC_W-1:0] rd_earliest,
    output logic [1:0]       rd_lo_net,
    output logic [1:0]       rd_hi_net,
    output logic             rd_err
);

    sb_entry_t new_ent;
    sb_entry_t look_ent;
    logic      wr_take;

    always_comb begin
        wr_err        = wr_en && (wr_dom == 2'(DOM_BAD));
        wr_take       = wr_en && !wr_err;
        new_ent.valid = 1'b1;
        new_ent.dom   = dom_e'(wr_dom);
        new_ent.wide  = wr_wide;
        new_ent.done  = wr_done;
    end

    fwd_sb_table #(.NUM_TAGS(NUM_TAGS)) u_table (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_take),
        .wr_tag (wr_tag),
        .wr_ent (new_ent),
        .rd_tag (rd_tag),
        .rd_ent (look_ent)
    );

    fwd_sb_eval #(.XING_PEN(XING_PEN)) u_eval (
        .ent      (look_ent),
        .cons_dom (rd_dom),
        .cur_cyc  (cur_cyc),
        .ready    (rd_ready),
        .earliest (rd_earliest),
        .lo_net   (rd_lo_net),
        .hi_net   (rd_hi_net),
        .cons_err (rd_err)
    );

endmodule

// File: rtl/fwd_sb_checker.sv
module fwd_sb_checker
    import fwd_sb_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic [CYC_W-1:0] cur_cyc,
    input logic             wr_en,
    input logic [4:0]       wr_tag,
    input logic [1:0]       wr_dom,
    input logic             wr_err,
    input logic [4:0]       rd_tag,
    input logic [1:0]       rd_dom,
    input logic             rd_ready,
    input logic [CYC_W-1:0] rd_earliest,
    input logic [1:0]       rd_lo_net,
    input logic [1:0]       rd_hi_net,
    input logic             rd_err
);

    // R1: the first cycle out of reset holds nothing
    p_empty_after_reset_r1: assert property (@(posedge clk)
        $fell(rst) |-> (!rd_ready && rd_earliest == '1 && rd_lo_net == NET_NONE));

    // R2: a legal write is seen on the next cycle by a lookup of that tag
    p_write_visible_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_dom != 2'd3) |=> (rd_tag != $past(wr_tag) || rd_lo_net != NET_NONE));

    // R5: a high half always rides SIMD with the low half on FP
    p_wide_split_r5: assert property (@(posedge clk) disable iff (rst)
        (rd_hi_net != NET_NONE) |-> (rd_lo_net == 2'd2 && rd_hi_net == 2'd1));

    // R6: ready never precedes the earliest cycle
    p_ready_time_r6: assert property (@(posedge clk) disable iff (rst)
        rd_ready |-> (cur_cyc >= rd_earliest && rd_lo_net != NET_NONE));

    // R7: illegal producer domain flags an error
    p_bad_write_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_dom == 2'd3) |-> wr_err);

    // R8: illegal consumer domain is never ready
    p_bad_lookup_r8: assert property (@(posedge clk) disable iff (rst)
        (rd_dom == 2'd3) |-> (rd_err && !rd_ready && rd_earliest == '1));

endmodule

bind fwd_scoreboard fwd_sb_checker u_chk (.*);

// File: tb/fwd_scoreboard_bench.sv
module fwd_scoreboard_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NT = 32;
    localparam int CW = fwd_sb_pkg::CYC_W;
    localparam int MAXC = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [CW-1:0] cur_cyc = '0;
    logic          wr_en = 1'b0;
    logic [4:0]    wr_tag = '0;
    logic [1:0]    wr_dom = '0;
    logic          wr_wide = 1'b0;
    logic [CW-1:0] wr_done = '0;
    logic          wr_err;
    logic [4:0]    rd_tag = '0;
    logic [1:0]    rd_dom = '0;
    logic          rd_ready;
    logic [CW-1:0] rd_earliest;
    logic [1:0]    rd_lo_net;
    logic [1:0]    rd_hi_net;
    logic          rd_err;

    fwd_scoreboard u_fwd_scoreboard (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    int m_valid [NT];
    int m_dom   [NT];
    int m_wide  [NT];
    int m_done  [NT];
    int cyc = 0;
    int checks = 0;
    int fails = 0;
    string force_tag = "";

    task automatic chk(input string r, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", r, what, act, exp, cyc);
        end
    endtask

    function automatic int pen(input int net, input int cd);
        return (net != cd) ? 1 : 0;
    endfunction

    task automatic compare();
        int t, cd, e, lo, hi, rdy, e0, e1;
        string r;
        t = int'(rd_tag);
        cd = int'(rd_dom);
        if (cd == 3) begin
            r = "R8"; e = MAXC; rdy = 0;
        end else if (m_valid[t] == 0) begin
            r = "R1"; e = MAXC; rdy = 0;
        end else begin
            if (m_wide[t] != 0) begin
                r = "R5";
                e0 = m_done[t] + pen(2, cd);
                e1 = m_done[t] + pen(1, cd);
                e = (e0 > e1) ? e0 : e1;
            end else begin
                r = (m_dom[t] == cd) ? "R3" : "R4";
                e = m_done[t] + pen(m_dom[t], cd);
            end
            if (e > MAXC) begin e = MAXC; r = "R9"; end
            rdy = (cyc >= e) ? 1 : 0;
        end
        if (m_valid[t] == 0) begin
            lo = 3; hi = 3;
        end else if (m_wide[t] != 0) begin
            lo = 2; hi = 1;
        end else begin
            lo = m_dom[t]; hi = 3;
        end
        if (force_tag != "") r = force_tag;
        chk(r, "earliest", int'(rd_earliest), e);
        chk((force_tag != "") ? force_tag : "R6", "ready", int'(rd_ready), rdy);
        chk((m_wide[t] != 0) ? "R5" : "R10", "lo_net", int'(rd_lo_net), lo);
        chk((m_wide[t] != 0) ? "R5" : "R10", "hi_net", int'(rd_hi_net), hi);
        chk("R8", "rd_err", int'(rd_err), (cd == 3) ? 1 : 0);
        chk("R7", "wr_err", int'(wr_err), (wr_en && wr_dom == 2'd3) ? 1 : 0);
    endtask

    task automatic step();
        @(posedge clk);
        if (rst) begin
            for (int i = 0; i < NT; i++) m_valid[i] = 0;
        end else if (wr_en && wr_dom != 2'd3) begin
            m_valid[wr_tag] = 1;
            m_dom[wr_tag]   = int'(wr_dom);
            m_wide[wr_tag]  = int'(wr_wide);
            m_done[wr_tag]  = int'(wr_done);
        end
        @(negedge clk);
        if (!rst) compare();
        cyc++;
        cur_cyc = CW'(cyc);
    endtask

    task automatic wr(input int tag, input int dom, input int wide, input int done);
        wr_en = 1'b1; wr_tag = 5'(tag); wr_dom = 2'(dom);
        wr_wide = 1'(wide); wr_done = CW'(done);
    endtask

    task automatic look(input int tag, input int dom);
        rd_tag = 5'(tag); rd_dom = 2'(dom);
    endtask

    initial begin
        for (int i = 0; i < NT; i++) begin
            m_valid[i] = 0; m_dom[i] = 0; m_wide[i] = 0; m_done[i] = 0;
        end
        repeat (3) step();
        rst = 1'b0;
        // R1: empty table after reset
        force_tag = "R1";
        look(0, 0); step();
        look(31, 2); step();
        force_tag = "";
        // R3: same domain, narrow, with ready rising on time (R6)
        wr(3, 0, 0, cyc + 3); look(3, 0); step();
        wr_en = 1'b0;
        for (int k = 0; k < 4; k++) step();
        // R4: cross-domain lookup
        wr(4, 1, 0, cyc + 2); look(4, 2); step();
        wr_en = 1'b0;
        for (int k = 0; k < 4; k++) step();
        // R2: overwrite tag 3 with a wide result
        force_tag = "R2";
        wr(3, 2, 1, cyc + 2); look(3, 0); step();
        wr_en = 1'b0; step();
        force_tag = "";
        // R5: wide seen by every consumer domain
        for (int d = 0; d < 3; d++) begin
            look(3, d); step(); step();
        end
        // R7: illegal producer domain dropped
        wr(7, 3, 0, cyc); look(7, 0); step();
        wr_en = 1'b0; force_tag = "R7"; step(); step(); force_tag = "";
        // R8: illegal consumer domain
        look(3, 3); step(); step();
        // R9: saturation of the crossing cycle
        wr(9, 0, 0, MAXC); look(9, 1); step();
        wr_en = 1'b0; step(); step();
        look(9, 0); step();
        // random traffic covering R2..R10
        for (int n = 0; n < 3000; n++) begin
            if ($urandom_range(0, 2) != 0) begin
                int d;
                d = ($urandom_range(0, 15) == 0) ? 3 : int'($urandom_range(0, 2));
                wr(int'($urandom_range(0, NT - 1)), d, int'($urandom_range(0, 1)),
                   cyc + int'($urandom_range(0, 6)));
            end else begin
                wr_en = 1'b0;
            end
            look(int'($urandom_range(0, NT - 1)),
                 ($urandom_range(0, 15) == 0) ? 3 : int'($urandom_range(0, 2)));
            step();
        end
        wr_en = 1'b0;
        step();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule